// File: doc/BRIEF.md
# Serial Receiver with Marked-Character Address Filter

This block receives asynchronous serial characters on a single line, oversampled by a 16x tick that an external baud generator provides. A frame carries 8, 9 or 10 payload bits after the start bit. The payload length and the position of an optional parity bit come from a small set of configuration inputs. Each completed character goes through an address filter before it reaches a one-entry data buffer. The filter has two comparators. When a comparator is enabled, only characters whose top data bit is set may enter the buffer, and only when they equal that comparator's match value.

On a multidrop line, address characters carry the top data bit set. A node enables one or both comparators with its own addresses, and the buffer then holds only the addresses meant for it. Every accepted character produces a one-clock ready pulse. The buffered word, its parity-error flag and its framing-error flag hold until the next accepted character. Rejected characters leave no trace at the outputs.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_data, rx_rdy, rx_perr and rx_ferr are all zero.
- R2: The payload bit count is 8, plus 1 when cfg_nine is set, plus 1 when cfg_tenth is set. Payload bits arrive least significant first. The data word is the payload without its parity bit, and rx_data holds it zero-extended to 9 bits.
- R3: With cfg_par_en set, parity is always the last payload bit: bit 8 of the payload when cfg_nine is clear (7 data bits), bit 9 when only cfg_nine is set (8 data bits), and bit 10 when cfg_tenth is also set (9 data bits). cfg_tenth is only used together with cfg_nine and cfg_par_en.
- R4: Parity covers the data bits plus the parity bit. The count of ones is even when cfg_par_odd is 0 and odd when it is 1. rx_perr is written only with an accepted character: it is set when the check fails and cleared when it passes, and it is always 0 when parity is disabled.
- R5: With both bits of match_en clear, every received character is written to the buffer.
- R6: With any bit of match_en set, a character whose top data bit is 0 is dropped, even if it equals a match value.
- R7: A character whose top data bit is 1 is accepted when it equals match_val[i] for some i with match_en[i] set. A match against a disabled comparator does not count, and with both enabled either match suffices.
- R8: rx_rdy is high for exactly one clock per accepted character and never for a dropped one. rx_data, rx_perr and rx_ferr change only in the cycle rx_rdy rises.
- R9: A start bit must still read low at its middle sample. A shorter low pulse produces no character.
- R10: If the middle samples of the stop bit vote low, the character is still subject to filtering, and rx_ferr is set when it is written. A high stop bit clears rx_ferr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| cfg_nine | input | 1 | Adds a ninth payload bit |
| cfg_par_en | input | 1 | Last payload bit is parity |
| cfg_par_odd | input | 1 | Odd parity when set, even when clear |
| cfg_tenth | input | 1 | Adds a tenth payload bit (parity position) |
| match_en | input | 2 | Per-comparator filter enable |
| match_val | input | 2x9 | Per-comparator match value |
| rx_data | output | 9 | Buffered data word |
| rx_rdy | output | 1 | One-clock pulse when the buffer is written |
| rx_perr | output | 1 | Parity error of the buffered word |
| rx_ferr | output | 1 | Framing error of the buffered word |

## Verification
The assertions assume that cfg_tenth is never raised without cfg_nine and cfg_par_en. They also assume that configuration and match inputs are static while a frame is in flight, because the filter and parity checks compare each result with the settings of the cycle before. The stimulus changes configuration only during idle gaps of several bit times between frames, and it keeps the illegal tenth-bit combination out of every step. The tick runs at a fixed 1-in-2 rate, and each bit lasts exactly 16 ticks. The ready pulse always therefore falls in the middle of the stop bit.

// File: rtl/uarx_pkg.sv
package uarx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_phase_e;

  // two-of-three majority of the samples around mid-bit
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uarx_sampler.sv
module uarx_sampler
  import uarx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int FRAME_MAX = 10,
  parameter int LEN_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  input  logic [LEN_W-1:0]     n_bits,
  output logic [FRAME_MAX-1:0] bits,
  output logic                 done,
  output logic                 stop_hi
);
  localparam int CNT_W = $clog2(OSR);
  localparam int MID   = OSR / 2 - 1;
  localparam logic [CNT_W-1:0] P_EARLY = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] P_MID   = CNT_W'(MID);
  localparam logic [CNT_W-1:0] P_LATE  = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] P_LAST  = CNT_W'(OSR - 1);

  rx_phase_e        phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic [LEN_W-1:0] idx;
  logic             s_early;
  logic             s_mid;
  logic             vote;

  assign nxt  = cnt + 1'b1;
  assign vote = vote3(s_early, s_mid, line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      s_early <= 1'b1;
      s_mid   <= 1'b1;
      bits    <= '0;
      done    <= 1'b0;
      stop_hi <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (phase)
        RX_IDLE: begin
          if (tick && !line) begin
            phase <= RX_START;
            cnt   <= '0;
            bits  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            cnt <= nxt;
            if (nxt == P_MID && line) begin
              phase <= RX_IDLE;
            end else if (cnt == P_LAST) begin
              phase <= RX_BITS;
              idx   <= '0;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            cnt <= nxt;
            if (nxt == P_EARLY) s_early <= line;
            if (nxt == P_MID)   s_mid   <= line;
            if (nxt == P_LATE) begin
              for (int i = 0; i < FRAME_MAX; i++) begin
                if (LEN_W'(i) == idx) bits[i] <= vote;
              end
            end
            if (cnt == P_LAST) begin
              if (idx == n_bits - 1'b1) phase <= RX_STOP;
              else                      idx   <= idx + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            cnt <= nxt;
            if (nxt == P_EARLY) s_early <= line;
            if (nxt == P_MID)   s_mid   <= line;
            if (nxt == P_LATE) begin
              done    <= 1'b1;
              stop_hi <= vote;
              phase   <= RX_IDLE;
            end
          end
        end
        default: phase <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uarx_match.sv
module uarx_match #(
  parameter int W  = 9,
  parameter int NM = 2
) (
  input  logic [W-1:0]         word,
  input  logic                 marked,
  input  logic [NM-1:0]        en,
  input  logic [NM-1:0][W-1:0] vals,
  output logic                 keep
);
  logic [NM-1:0] hit;

  for (genvar g = 0; g < NM; g++) begin : g_cmp
    assign hit[g] = en[g] && (word == vals[g]);
  end

  // no comparator enabled: open; otherwise a marked word must hit one
  assign keep = (en == '0) || (marked && (|hit));

endmodule

// File: rtl/uarx_hold.sv
module uarx_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         perr_in,
  input  logic         ferr_in,
  output logic [W-1:0] dout,
  output logic         rdy,
  output logic         perr,
  output logic         ferr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      rdy  <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      rdy <= wr;
      if (wr) begin
        dout <= din;
        perr <= perr_in;
        ferr <= ferr_in;
      end
    end
  end

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int BASE_W    = 8,
  parameter int OSR       = 16,
  parameter int NUM_MATCH = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rx_in,
  input  logic                           os_tick,
  input  logic                           cfg_nine,
  input  logic                           cfg_par_en,
  input  logic                           cfg_par_odd,
  input  logic                           cfg_tenth,
  input  logic [NUM_MATCH-1:0]           match_en,
  input  logic [NUM_MATCH-1:0][BASE_W:0] match_val,
  output logic [BASE_W:0]                rx_data,
  output logic                           rx_rdy,
  output logic                           rx_perr,
  output logic                           rx_ferr
);
  localparam int MAX_W     = BASE_W + 1;
  localparam int FRAME_MAX = BASE_W + 2;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  function automatic logic [LEN_W-1:0] frame_len(input logic nine, input logic tenth);
    return LEN_W'(BASE_W) + LEN_W'(nine) + LEN_W'(tenth);
  endfunction

  function automatic logic [LEN_W-1:0] word_len(input logic [LEN_W-1:0] flen, input logic par);
    return flen - LEN_W'(par);
  endfunction

  function automatic logic [MAX_W-1:0] take_word(input logic [FRAME_MAX-1:0] b,
                                                 input logic [LEN_W-1:0] wlen);
    logic [MAX_W-1:0] w;
    w = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (LEN_W'(i) < wlen) w[i] = b[i];
    end
    return w;
  endfunction

  function automatic logic pick_bit(input logic [FRAME_MAX-1:0] b, input logic [LEN_W-1:0] pos);
    logic v;
    v = 1'b0;
    for (int i = 0; i < FRAME_MAX; i++) begin
      if (LEN_W'(i) == pos) v = b[i];
    end
    return v;
  endfunction

  function automatic logic parity_bad(input logic [MAX_W-1:0] w, input logic pbit, input logic odd);
    return (^w) ^ pbit ^ odd;
  endfunction

  // line synchronizer, idle high
  logic [SYNC_LEN-1:0] sync_q;
  logic                line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], rx_in};
  end
  assign line_s = sync_q[SYNC_LEN-1];

  logic [LEN_W-1:0]     flen;
  logic [LEN_W-1:0]     wlen;
  logic [FRAME_MAX-1:0] frm_bits;
  logic                 frm_done;
  logic                 frm_stop_hi;
  logic [MAX_W-1:0]     frm_word;
  logic                 frm_pbit;
  logic                 frm_marked;
  logic                 frm_keep;
  logic                 frm_perr;
  logic                 frm_write;

  assign flen = frame_len(cfg_nine, cfg_tenth);
  assign wlen = word_len(flen, cfg_par_en);

  uarx_sampler #(
    .OSR      (OSR),
    .FRAME_MAX(FRAME_MAX),
    .LEN_W    (LEN_W)
  ) u_samp (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (os_tick),
    .line   (line_s),
    .n_bits (flen),
    .bits   (frm_bits),
    .done   (frm_done),
    .stop_hi(frm_stop_hi)
  );

  assign frm_word   = take_word(frm_bits, wlen);
  assign frm_pbit   = pick_bit(frm_bits, flen - 1'b1);
  assign frm_marked = pick_bit({1'b0, frm_word}, wlen - 1'b1);
  assign frm_perr   = cfg_par_en && parity_bad(frm_word, frm_pbit, cfg_par_odd);

  uarx_match #(
    .W (MAX_W),
    .NM(NUM_MATCH)
  ) u_match (
    .word  (frm_word),
    .marked(frm_marked),
    .en    (match_en),
    .vals  (match_val),
    .keep  (frm_keep)
  );

  assign frm_write = frm_done && frm_keep;

  uarx_hold #(
    .W(MAX_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (frm_write),
    .din    (frm_word),
    .perr_in(frm_perr),
    .ferr_in(!frm_stop_hi),
    .dout   (rx_data),
    .rdy    (rx_rdy),
    .perr   (rx_perr),
    .ferr   (rx_ferr)
  );

endmodule

// File: rtl/uarx_checker.sv
module uarx_checker #(
  parameter int W  = 9,
  parameter int NM = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_nine,
  input logic          cfg_par_en,
  input logic          cfg_tenth,
  input logic [NM-1:0] match_en,
  input logic [W-1:0]  rx_data,
  input logic          rx_rdy,
  input logic          rx_perr,
  input logic          rx_ferr,
  input logic          frm_done,
  input logic          frm_keep,
  input logic          frm_marked
);

  // tenth-bit mode only alongside nine-bit frames and parity
  assert_tenth_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tenth |-> (cfg_nine && cfg_par_en));

  // no parity checking, no parity error reported
  assert_perr_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy && !$past(cfg_par_en)) |-> !rx_perr);

  // open filter: each completed frame reaches the buffer
  assert_open_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && (match_en == '0)) |=> rx_rdy);

  // filter on: only marked characters are written
  assert_marked_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy && $past(|match_en)) |-> $past(frm_marked));

  assert_rdy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy |=> !rx_rdy);

  assert_rdy_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy |-> $past(frm_done && frm_keep));

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rdy |-> ($stable(rx_data) && $stable(rx_perr) && $stable(rx_ferr)));

endmodule

bind uart_addr_rx uarx_checker #(
  .W (MAX_W),
  .NM(NUM_MATCH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_nine  (cfg_nine),
  .cfg_par_en(cfg_par_en),
  .cfg_tenth (cfg_tenth),
  .match_en  (match_en),
  .rx_data   (rx_data),
  .rx_rdy    (rx_rdy),
  .rx_perr   (rx_perr),
  .rx_ferr   (rx_ferr),
  .frm_done  (frm_done),
  .frm_keep  (frm_keep),
  .frm_marked(frm_marked)
);

// File: tb/uart_addr_rx_test.sv
module uart_addr_rx_test;
  localparam int BIT = 32; // 16 ticks, one tick every 2 clocks

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rx_in = 1'b1;
  logic            os_tick = 1'b0;
  logic            cfg_nine = 1'b0;
  logic            cfg_par_en = 1'b0;
  logic            cfg_par_odd = 1'b0;
  logic            cfg_tenth = 1'b0;
  logic [1:0]      match_en = '0;
  logic [1:0][8:0] match_val = '0;
  logic [8:0]      rx_data;
  logic            rx_rdy;
  logic            rx_perr;
  logic            rx_ferr;

  uart_addr_rx uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_in      (rx_in),
    .os_tick    (os_tick),
    .cfg_nine   (cfg_nine),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .cfg_tenth  (cfg_tenth),
    .match_en   (match_en),
    .match_val  (match_val),
    .rx_data    (rx_data),
    .rx_rdy     (rx_rdy),
    .rx_perr    (rx_perr),
    .rx_ferr    (rx_ferr)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    os_tick = ~os_tick;
  end

  typedef struct packed {
    logic [8:0] d;
    logic       pe;
    logic       fe;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  int   n_chk = 0;
  int   n_bad = 0;
  int   pulses = 0;
  logic last_rdy = 1'b0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items as ready pulses appear
  always @(negedge clk) begin
    if (rst_n && rx_rdy) begin
      pulses++;
      check(!last_rdy, "R8", "ready pulse longer than one clock", 1, 0);
      if (sb.size() == 0) begin
        check(0, "R8", "ready with nothing expected", int'(rx_data), 0);
      end else begin
        mon_e = sb.pop_front();
        check(rx_data == mon_e.d, "R2", "buffered word", int'(rx_data), int'(mon_e.d));
        check(rx_perr == mon_e.pe, "R4", "parity flag", int'(rx_perr), int'(mon_e.pe));
        check(rx_ferr == mon_e.fe, "R10", "framing flag", int'(rx_ferr), int'(mon_e.fe));
      end
    end
    last_rdy = rx_rdy;
  end

  task automatic send(input logic [9:0] pl, input int n, input bit bad_stop);
    rx_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_in = pl[i];
      repeat (BIT) @(negedge clk);
    end
    if (bad_stop) begin
      rx_in = 1'b0;
      repeat (BIT * 3 / 4) @(negedge clk);
      rx_in = 1'b1;
      repeat (BIT / 4) @(negedge clk);
    end else begin
      rx_in = 1'b1;
      repeat (BIT) @(negedge clk);
    end
    rx_in = 1'b1;
    repeat (3 * BIT) @(negedge clk);
  endtask

  // driver: model the frame, push the expected item, send, confirm outcome
  task automatic xmit(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                      input string req);
    int         flen;
    int         wlen;
    logic [8:0] w;
    logic [9:0] pl;
    bit         msb;
    bit         keep;
    int         p0;
    logic [8:0] d0;
    flen = 8 + int'(cfg_nine) + int'(cfg_tenth);
    wlen = flen - int'(cfg_par_en);
    w    = '0;
    for (int i = 0; i < wlen; i++) w[i] = d[i];
    pl = {1'b0, w};
    if (cfg_par_en) pl[wlen] = (^w) ^ cfg_par_odd ^ bad_par;
    msb  = w[wlen-1];
    keep = (match_en == 2'b00) ||
           (msb && ((match_en[0] && w == match_val[0]) ||
                    (match_en[1] && w == match_val[1])));
    if (keep) sb.push_back('{w, cfg_par_en && bad_par, bad_stop});
    p0 = pulses;
    d0 = rx_data;
    send(pl, flen, bad_stop);
    if (keep)
      check(pulses == p0 + 1 && sb.size() == 0, req, "character should be kept",
            pulses - p0, 1);
    else
      check(pulses == p0 && rx_data == d0, req, "character should be dropped",
            pulses - p0, 0);
  endtask

  task automatic cfg(input bit nine, input bit par, input bit odd, input bit tenth);
    cfg_nine = nine;
    cfg_par_en = par;
    cfg_par_odd = odd;
    cfg_tenth = tenth;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int p0;
    repeat (10) @(negedge clk);
    // R1: reset state
    check(rx_data == 0 && rx_rdy == 0, "R1", "data/ready in reset", int'(rx_data), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(rx_data == 0, "R1", "data after reset", int'(rx_data), 0);
    check(!rx_rdy && !rx_perr && !rx_ferr, "R1", "flags after reset",
          int'({rx_rdy, rx_perr, rx_ferr}), 0);

    // R2 / R5: eight data bits, no parity, open filter
    cfg(0, 0, 0, 0);
    xmit(9'h035, 0, 0, "R5");
    xmit(9'h0CA, 0, 0, "R2");
    xmit(9'h000, 0, 0, "R5");
    xmit(9'h0FF, 0, 0, "R2");
    // R2: nine data bits
    cfg(1, 0, 0, 0);
    xmit(9'h1A5, 0, 0, "R2");
    xmit(9'h05A, 0, 0, "R2");
    // R3 / R4: seven data bits plus parity in bit 8
    cfg(0, 1, 0, 0);
    xmit(9'h05A, 0, 0, "R3");
    xmit(9'h033, 1, 0, "R4");
    check(rx_perr == 1'b1, "R4", "even parity failure flagged", int'(rx_perr), 1);
    cfg(0, 1, 1, 0);
    xmit(9'h041, 0, 0, "R4");
    check(rx_perr == 1'b0, "R4", "odd parity pass clears flag", int'(rx_perr), 0);
    // R3: parity in the ninth bit
    cfg(1, 1, 0, 0);
    xmit(9'h0A7, 0, 0, "R3");
    xmit(9'h0E1, 1, 0, "R3");
    // R3: parity in the tenth bit, nine data bits
    cfg(1, 1, 1, 1);
    xmit(9'h1C3, 0, 0, "R3");
    xmit(9'h0F0, 1, 0, "R3");
    check(rx_perr == 1'b1, "R4", "tenth-bit parity failure flagged", int'(rx_perr), 1);
    xmit(9'h111, 0, 0, "R4");

    // address filter, eight data bits, no parity
    cfg(0, 0, 0, 0);
    match_val[0] = 9'h093;
    match_val[1] = 9'h0C0;
    match_en = 2'b01;
    repeat (4) @(negedge clk);
    xmit(9'h013, 0, 0, "R6");
    xmit(9'h093, 0, 0, "R7");
    xmit(9'h094, 0, 0, "R7");
    xmit(9'h0C0, 0, 0, "R7");
    match_en = 2'b11;
    repeat (4) @(negedge clk);
    xmit(9'h0C0, 0, 0, "R7");
    xmit(9'h093, 0, 0, "R7");
    xmit(9'h0C1, 0, 0, "R7");
    match_en = 2'b10;
    repeat (4) @(negedge clk);
    xmit(9'h093, 0, 0, "R7");
    // R6: unmarked value equal to a match value is still dropped
    match_val[1] = 9'h013;
    repeat (4) @(negedge clk);
    xmit(9'h013, 0, 0, "R6");

    // R4: dropped character with bad parity leaves the flag alone
    cfg(1, 1, 0, 0);
    match_val[0] = 9'h095;
    match_en = 2'b01;
    repeat (4) @(negedge clk);
    xmit(9'h095, 0, 0, "R7");
    xmit(9'h096, 1, 0, "R4");
    check(rx_perr == 1'b0, "R4", "flag after dropped bad-parity character", int'(rx_perr), 0);

    // R10: framing error, then clean stop clears it
    cfg(0, 0, 0, 0);
    match_en = 2'b00;
    repeat (4) @(negedge clk);
    xmit(9'h06C, 0, 1, "R10");
    check(rx_ferr == 1'b1, "R10", "framing flag set", int'(rx_ferr), 1);
    xmit(9'h06D, 0, 0, "R10");
    check(rx_ferr == 1'b0, "R10", "framing flag cleared", int'(rx_ferr), 0);
    // R10: framing error on a filtered-out character is not reported
    match_en = 2'b01;
    repeat (4) @(negedge clk);
    xmit(9'h011, 0, 1, "R10");
    check(rx_ferr == 1'b0, "R10", "dropped frame leaves flag", int'(rx_ferr), 0);
    match_en = 2'b00;
    repeat (4) @(negedge clk);

    // R9: short low pulse on the line is not a start bit
    p0 = pulses;
    rx_in = 1'b0;
    repeat (6) @(negedge clk);
    rx_in = 1'b1;
    repeat (20 * BIT) @(negedge clk);
    check(pulses == p0, "R9", "glitch produced a character", pulses - p0, 0);
    xmit(9'h0B4, 0, 0, "R9");

    check(sb.size() == 0, "R8", "expected items left over", sb.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule